// File: doc/BRIEF.md
# Alternating-Descriptor One-Shot DMA Channel

This block is one DMA channel that holds two identical descriptor sets, each made of a start address, a byte length and a command word. Only one set is active at a time. The engine runs a one-shot transfer from the active set while software fills in the other set. When the transfer ends, the active role passes to the other set, and that set starts at once if software has already armed it. A descriptor runs exactly once and is never reloaded by hardware.

Software reaches the channel over a small word-addressed register port. Read data comes back one cycle after the read strobe. Data moves over a memory master port of the request/acknowledge kind, one 32-bit word per acknowledged beat. A peripheral-side port supplies the words for memory writes and receives the words from memory reads, with one strobe per beat. Each completion sets a sticky done flag, and that flag can drive an interrupt line.

Top module: `pp_dma_channel`

## Requirements
- R1: Set s (s = 0 or 1) occupies offsets 0x10*s + {0x0 address, 0x4 length, 0x8 command}, and the control word sits at offset 0x20. Read data is presented on the cycle after `reg_rd`. Any other offset reads as zero.
- R2: In the command word, bit 0 is the start/armed flag and bit 1 is the direction. Direction 1 writes `dev_data_in` to memory. Direction 0 reads memory and presents each word on `dev_data_out`, qualified by `dev_strobe`.
- R3: The two low bits of a length write are dropped, so they always read as zero. A length of L bytes makes L/4 beats at addresses that start at the set's address and rise by 4 on each beat.
- R4: The engine leaves idle only when control bit 0 (enable) is 1 and the active set is armed. An armed set that is not the active set never starts from idle.
- R5: On completion, the engine clears the finished set's armed bit, sets control bit 8 (done), and toggles control bit 16 (active set index).
- R6: If the other set is already armed when a transfer completes, that set runs next without any software action.
- R7: A length of zero completes with no memory request.
- R8: Writes to the address, length or command of the active set while a transfer is running have no effect.
- R9: `irq_done` equals done AND control bit 1 (interrupt enable). Writing 1 to control bit 8 clears done. Control bit 17 reads 1 while a transfer runs.
- R10: Once `mem_req` is raised, it stays high with a stable `mem_addr` until `mem_ack` arrives.
- R11: After reset, every register reads zero, set 0 is active, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a memory write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted |
| dev_data_in | input | 32 | Peripheral word for memory writes |
| dev_data_out | output | 32 | Word read from memory |
| dev_strobe | output | 1 | One pulse per completed beat |
| irq_done | output | 1 | Completion interrupt |

## Verification
The assertions assume that `mem_ack` is only raised while `mem_req` is high. They also assume that `rst` holds long enough to clear every flop before the checks begin. The bench memory model satisfies the first assumption by deriving its acknowledge from the request it sees at the falling edge, so an acknowledge can never appear without a request. It inserts a programmable number of wait cycles so that request holding is exercised. Register traffic is driven at falling edges, one access per cycle. Transfers are waited on by polling the busy bit twice in a row, which spans the single idle cycle between two chained sets.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_AW     = 6;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  // offsets decoded by the register block
  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h20;
  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_LEN  = 2'd1;
  localparam logic [1:0] FLD_CMD  = 2'd2;

  // control word bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_IE   = 1;
  localparam int CTL_DONE = 8;
  localparam int CTL_ACT  = 16;
  localparam int CTL_BUSY = 17;

  typedef enum logic {ST_IDLE, ST_RUN} eng_state_t;
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [WORD_W-1:0]      reg_wdata,
  output logic [WORD_W-1:0]      reg_rdata,
  input  logic                   eng_busy,
  input  logic                   eng_active,
  input  logic                   eng_complete,
  output logic [1:0][ADDR_W-1:0] set_addr,
  output logic [1:0][LEN_W-1:0]  set_len,
  output logic [1:0]             set_dir,
  output logic [1:0]             set_armed,
  output logic                   ctl_en,
  output logic                   ctl_ie,
  output logic                   done_pend
);
  logic       sel_set;
  logic [1:0] field;
  logic       is_desc;
  logic       is_ctrl;

  assign sel_set = reg_addr[4];
  assign field   = reg_addr[3:2];
  assign is_desc = !reg_addr[5] && (reg_addr[1:0] == 2'b00) && (field != 2'b11);
  assign is_ctrl = (reg_addr == OFS_CTRL);

  // one descriptor set per generate iteration
  for (genvar g = 0; g < 2; g++) begin : g_set
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              dir_q;
    logic              armed_q;
    logic              wr_ok;
    logic              locked;

    assign locked = eng_busy && (eng_active == 1'(g));
    assign wr_ok  = reg_wr && is_desc && (sel_set == 1'(g)) && !locked;

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q  <= '0;
        len_q   <= '0;
        dir_q   <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        if (eng_complete && (eng_active == 1'(g)))
          armed_q <= 1'b0;
        if (wr_ok) begin
          case (field)
            FLD_ADDR: addr_q <= reg_wdata[ADDR_W-1:0];
            FLD_LEN:  len_q  <= {reg_wdata[LEN_W-1:2], 2'b00};
            FLD_CMD: begin
              armed_q <= reg_wdata[0];
              dir_q   <= reg_wdata[1];
            end
            default: ;
          endcase
        end
      end
    end

    assign set_addr[g]  = addr_q;
    assign set_len[g]   = len_q;
    assign set_dir[g]   = dir_q;
    assign set_armed[g] = armed_q;
  end

  logic ctl_wr;
  assign ctl_wr = reg_wr && is_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      ctl_ie    <= 1'b0;
      done_pend <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_en <= reg_wdata[CTL_EN];
        ctl_ie <= reg_wdata[CTL_IE];
      end
      if (eng_complete)
        done_pend <= 1'b1;
      else if (ctl_wr && reg_wdata[CTL_DONE])
        done_pend <= 1'b0;
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (is_ctrl) begin
      rd_mux[CTL_EN]   = ctl_en;
      rd_mux[CTL_IE]   = ctl_ie;
      rd_mux[CTL_DONE] = done_pend;
      rd_mux[CTL_ACT]  = eng_active;
      rd_mux[CTL_BUSY] = eng_busy;
    end else if (is_desc) begin
      case (field)
        FLD_ADDR: rd_mux = WORD_W'(set_addr[sel_set]);
        FLD_LEN:  rd_mux = WORD_W'(set_len[sel_set]);
        FLD_CMD:  rd_mux = {30'b0, set_dir[sel_set], set_armed[sel_set]};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctl_en,
  input  logic [1:0][ADDR_W-1:0] set_addr,
  input  logic [1:0][LEN_W-1:0]  set_len,
  input  logic [1:0]             set_dir,
  input  logic [1:0]             set_armed,
  input  logic                   mem_ack,
  output logic                   busy,
  output logic                   active,
  output logic                   complete,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(WORD_BYTES);

  eng_state_t        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              dir_q;

  assign busy     = (state == ST_RUN);
  assign complete = busy && (remain == '0);
  assign mem_req  = busy && (remain != '0);
  assign mem_we   = dir_q;
  assign mem_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      active   <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      dir_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctl_en && set_armed[active]) begin
            state    <= ST_RUN;
            cur_addr <= set_addr[active];
            remain   <= set_len[active];
            dir_q    <= set_dir[active];
          end
        end
        ST_RUN: begin
          if (complete) begin
            state  <= ST_IDLE;
            active <= ~active;
          end else if (mem_ack) begin
            cur_addr <= cur_addr + ADDR_STEP;
            remain   <= remain - LEN_STEP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic [31:0]       dev_data_in,
  output logic [31:0]       dev_data_out,
  output logic              dev_strobe,
  output logic              irq_done
);
  logic [1:0][ADDR_W-1:0] set_addr;
  logic [1:0][LEN_W-1:0]  set_len;
  logic [1:0]             set_dir;
  logic [1:0]             armed;
  logic                   ctl_en;
  logic                   ctl_ie;
  logic                   done_pend;
  logic                   eng_busy;
  logic                   eng_active;
  logic                   eng_complete;

  pp_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .eng_busy     (eng_busy),
    .eng_active   (eng_active),
    .eng_complete (eng_complete),
    .set_addr     (set_addr),
    .set_len      (set_len),
    .set_dir      (set_dir),
    .set_armed    (armed),
    .ctl_en       (ctl_en),
    .ctl_ie       (ctl_ie),
    .done_pend    (done_pend)
  );

  pp_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .ctl_en    (ctl_en),
    .set_addr  (set_addr),
    .set_len   (set_len),
    .set_dir   (set_dir),
    .set_armed (armed),
    .mem_ack   (mem_ack),
    .busy      (eng_busy),
    .active    (eng_active),
    .complete  (eng_complete),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
  );

  assign mem_wdata    = dev_data_in;
  assign dev_data_out = mem_rdata;
  assign dev_strobe   = mem_req && mem_ack;
  assign irq_done     = done_pend && ctl_ie;
endmodule

// File: rtl/pp_dma_channel_sva.sv
module pp_dma_channel_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              active,
  input logic              complete,
  input logic [1:0]        armed,
  input logic              enable,
  input logic              done_pend
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) ##1 mem_req |-> (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R3

  AST_START_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(armed[active]) && $past(enable))); // R4

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    complete |=> done_pend); // R5

  AST_ACTIVE_FLIP: assert property (@(posedge clk) disable iff (rst)
    complete |=> (active != $past(active))); // R5

  AST_ARMED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    complete |=> !armed[$past(active)]); // R5

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !complete) |=> $stable(active)); // R8
endmodule

bind pp_dma_channel pp_dma_channel_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .busy      (eng_busy),
  .active    (eng_active),
  .complete  (eng_complete),
  .armed     (armed),
  .enable    (ctl_en),
  .done_pend (done_pend)
);

// File: tb/pp_dma_channel_bench.sv
module pp_dma_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ack = 1'b0;
  logic [31:0] dev_data_in;
  logic [31:0] dev_data_out;
  logic        dev_strobe;
  logic        irq_done;

  int tests = 0;
  int fails = 0;
  int stall = 0;
  int wait_cnt = 0;
  int beats = 0;
  int req_cycles = 0;
  int rd_n = 0;
  logic [31:0] rd_log [0:63];
  logic [31:0] mem [0:255];
  logic exp_act = 1'b0;

  always #10 clk = ~clk;

  pp_dma_channel u_pp_dma_channel (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .dev_data_in(dev_data_in), .dev_data_out(dev_data_out), .dev_strobe(dev_strobe),
    .irq_done(irq_done)
  );

  assign dev_data_in = {8'hC3, mem_addr[23:0]};
  assign mem_rdata   = mem[mem_addr[9:2]];

  // memory model: acknowledge after `stall` wait cycles
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= stall) begin mem_ack <= 1'b1; wait_cnt <= 0; end
      else wait_cnt <= wait_cnt + 1;
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (mem_req) req_cycles <= req_cycles + 1;
    if (mem_req && mem_ack) begin
      beats <= beats + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (dev_strobe && rd_n < 64) begin
      rd_log[rd_n] <= dev_data_out;
      rd_n <= rd_n + 1;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_quiet();
    logic [31:0] c;
    int idle_run = 0;
    for (int i = 0; i < 4000 && idle_run < 2; i++) begin
      reg_read(6'h20, c);
      idle_run = c[17] ? 0 : idle_run + 1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(6'h20, d);
    check(d == 32'h0, "R11 ctrl after reset", d, 32'h0);
    reg_read(6'h00, d);
    check(d == 32'h0, "R11 set0 address after reset", d, 32'h0);
    reg_read(6'h18, d);
    check(d == 32'h0, "R11 set1 command after reset", d, 32'h0);
    check({mem_req, irq_done} == 2'b00, "R11 no request or irq", {30'b0, mem_req, irq_done}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    reg_write(6'h00, 32'h0000_0100);
    reg_write(6'h10, 32'h0000_0200);
    reg_write(6'h14, 32'h0000_0020);
    reg_read(6'h00, d);
    check(d == 32'h100, "R1 set0 address readback", d, 32'h100);
    reg_read(6'h10, d);
    check(d == 32'h200, "R1 set1 address readback", d, 32'h200);
    reg_read(6'h14, d);
    check(d == 32'h20, "R1 set1 length readback", d, 32'h20);
    reg_read(6'h0C, d);
    check(d == 32'h0, "R1 unmapped offset reads zero", d, 32'h0);
    reg_read(6'h24, d);
    check(d == 32'h0, "R1 offset above control reads zero", d, 32'h0);
    reg_write(6'h04, 32'h0000_0013);
    reg_read(6'h04, d);
    check(d == 32'h10, "R3 length low bits dropped", d, 32'h10);
  endtask

  task automatic t_write_xfer();
    logic [31:0] d;
    int b0 = beats;
    reg_write(6'h20, 32'h3);
    reg_write(6'h00, 32'h0000_0100);
    reg_write(6'h04, 32'h0000_0010);
    reg_write(6'h08, 32'h3);
    wait_quiet();
    exp_act = ~exp_act;
    check(beats - b0 == 4, "R3 four beats for 16 bytes", 32'(beats - b0), 32'd4);
    for (int i = 0; i < 4; i++)
      check(mem[8'h40 + i] == {8'hC3, 24'h100 + 24'(4 * i)}, "R2 memory write data",
            mem[8'h40 + i], {8'hC3, 24'h100 + 24'(4 * i)});
    reg_read(6'h20, d);
    check(d == 32'h0001_0103, "R5 done set and active toggled", d, 32'h0001_0103);
    reg_read(6'h08, d);
    check(d == 32'h2, "R5 armed cleared, direction kept", d, 32'h2);
    check(irq_done == 1'b1, "R9 irq with enable", {31'b0, irq_done}, 32'h1);
    reg_write(6'h20, 32'h103);
    check(irq_done == 1'b0, "R9 irq cleared by write-one", {31'b0, irq_done}, 32'h0);
  endtask

  task automatic t_pingpong();
    logic [31:0] d;
    int r0 = rd_n;
    for (int i = 0; i < 8; i++) begin
      mem[8'h80 + i] = 32'h1111_0000 + 32'(i);
      mem[8'hC0 + i] = 32'h2222_0000 + 32'(i);
    end
    reg_write(6'h20, 32'h2);
    reg_write(6'h10, 32'h0000_0200);
    reg_write(6'h14, 32'h0000_0008);
    reg_write(6'h18, 32'h1);
    reg_write(6'h00, 32'h0000_0300);
    reg_write(6'h04, 32'h0000_000C);
    reg_write(6'h08, 32'h1);
    reg_write(6'h20, 32'h3);
    wait_quiet();
    check(rd_n - r0 == 5, "R6 both sets ran", 32'(rd_n - r0), 32'd5);
    check(rd_log[r0] == 32'h1111_0000, "R6 active set runs first", rd_log[r0], 32'h1111_0000);
    check(rd_log[r0 + 1] == 32'h1111_0001, "R2 read data order", rd_log[r0 + 1], 32'h1111_0001);
    check(rd_log[r0 + 2] == 32'h2222_0000, "R6 other set follows", rd_log[r0 + 2], 32'h2222_0000);
    check(rd_log[r0 + 4] == 32'h2222_0002, "R3 last word of second set", rd_log[r0 + 4], 32'h2222_0002);
    reg_read(6'h20, d);
    check(d[16] == exp_act, "R5 active after two flips", {31'b0, d[16]}, {31'b0, exp_act});
    reg_read(6'h08, d);
    check(d[0] == 1'b0, "R5 set0 disarmed", d, 32'h0);
    reg_write(6'h20, 32'h103);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    int q0 = req_cycles;
    reg_write(6'h20, 32'h1);
    reg_write(6'h14, 32'h0);
    reg_write(6'h18, 32'h1);
    wait_quiet();
    exp_act = ~exp_act;
    check(req_cycles == q0, "R7 zero length makes no request", 32'(req_cycles - q0), 32'h0);
    reg_read(6'h20, d);
    check(d == {15'b0, 1'b0, exp_act, 7'b0, 1'b1, 7'b0, 1'b1}, "R7 zero length completes",
          d, {15'b0, 1'b0, exp_act, 7'b0, 1'b1, 7'b0, 1'b1});
    check(irq_done == 1'b0, "R9 irq masked when disabled", {31'b0, irq_done}, 32'h0);
    reg_write(6'h20, 32'h3);
    check(irq_done == 1'b1, "R9 irq follows enable", {31'b0, irq_done}, 32'h1);
    reg_write(6'h20, 32'h103);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    int q0;
    int b0;
    // exp_act is 0 here
    reg_write(6'h20, 32'h0);
    reg_write(6'h00, 32'h0000_0040);
    reg_write(6'h04, 32'h4);
    reg_write(6'h08, 32'h1);
    q0 = req_cycles;
    repeat (20) @(negedge clk);
    check(req_cycles == q0, "R4 no start while disabled", 32'(req_cycles - q0), 32'h0);
    b0 = beats;
    reg_write(6'h20, 32'h1);
    wait_quiet();
    exp_act = ~exp_act;
    check(beats - b0 == 1, "R4 start once enabled", 32'(beats - b0), 32'h1);
    // active is set 1; arm set 0 only
    reg_write(6'h00, 32'h0000_0044);
    reg_write(6'h04, 32'h4);
    reg_write(6'h08, 32'h1);
    q0 = req_cycles;
    repeat (20) @(negedge clk);
    check(req_cycles == q0, "R4 non-active armed set stays idle", 32'(req_cycles - q0), 32'h0);
    b0 = beats;
    reg_write(6'h14, 32'h0);
    reg_write(6'h18, 32'h1);
    wait_quiet();
    check(beats - b0 == 1, "R6 waiting set runs after chain", 32'(beats - b0), 32'h1);
    reg_read(6'h20, d);
    check(d[16] == exp_act, "R5 active after chain", {31'b0, d[16]}, {31'b0, exp_act});
    reg_write(6'h20, 32'h103);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    int b0 = beats;
    // exp_act is 1 here
    stall = 3;
    reg_write(6'h10, 32'h0000_0500);
    reg_write(6'h14, 32'h0000_0040);
    reg_write(6'h18, 32'h3);
    repeat (4) @(negedge clk);
    reg_read(6'h20, d);
    check(d[17] == 1'b1, "R9 busy bit while running", d, 32'h0002_0000);
    reg_write(6'h10, 32'h0000_0999);
    reg_write(6'h14, 32'h0000_0004);
    reg_write(6'h18, 32'h0);
    reg_read(6'h10, d);
    check(d == 32'h500, "R8 active address write ignored", d, 32'h500);
    reg_read(6'h14, d);
    check(d == 32'h40, "R8 active length write ignored", d, 32'h40);
    reg_read(6'h18, d);
    check(d == 32'h3, "R8 active command write ignored", d, 32'h3);
    reg_write(6'h00, 32'h0000_0600);
    reg_read(6'h00, d);
    check(d == 32'h600, "R8 idle set writable while busy", d, 32'h600);
    wait_quiet();
    exp_act = ~exp_act;
    check(beats - b0 == 16, "R10 all beats with wait states", 32'(beats - b0), 32'd16);
    check(mem[8'h4F] == 32'hC300_053C, "R3 final address reached", mem[8'h4F], 32'hC300_053C);
    stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_write_xfer();
    t_pingpong();
    t_zero();
    t_gating();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule